// File: doc/BRIEF.md
# Domain External Interrupt Summary Registers

This block gathers the external interrupt state of every per-domain interrupt controller attached to one hart. It presents that state to machine-level software as a read-only summary register with one bit per controller. Next to it sits a read/write enable register with the same layout. When any enabled summary bit is set, the block raises a local interrupt pending bit, which lives at position 16 of the machine interrupt-pending view. Supervisor software sees a copy of that bit only when the interrupt is delegated to it. Machine-level firmware uses the summary to learn that a domain that is not currently scheduled has work waiting.

Each controller is one of two kinds. A wired-type controller reports a single S-level pending line. A guest-capable (message-signalled) controller also reports a vector of VS-level pending lines, one per guest file. Controller numbers start at 1; number 0 means "no controller". An active-controller selection input picks which controller's S-level line and VS-level vector are passed on to the hart's normal pending paths. That selection never changes the summary. The enables never change the forwarded lines.

Registers are reached through a simple CSR port: an address, a write strobe and write data, a combinational read-data output and a hit flag. With a 32-bit register width, two extra high-half addresses alias bits 63:32 of the summary and the enable register. With a 64-bit width those addresses do not decode.

Top module: `dom_eint_summary`

## Requirements
- R1: Bit 0 of both the summary register and the enable register always reads 0, and writing 1 to bit 0 of the enable register leaves it 0.
- R2: For a wired-type controller k (type flag 0), summary bit k equals its S-level pending line; its VS-level lines are ignored.
- R3: For a guest-capable controller k (type flag 1), summary bit k is the OR of its S-level line and all of its VS-level lines.
- R4: The summary reflects controller state whatever the active selection holds, including 0 and numbers above the implemented count.
- R5: `m_lpend` is 1 exactly when the bitwise AND of summary and enable is nonzero.
- R6: `s_lpend` is 0 while `s_deleg` is 0, and equals `m_lpend` while `s_deleg` is 1.
- R7: For a selection n in 1..NCTL, `act_s_pend` carries controller n's S-level line. `act_vs_pend` carries its VS-level vector if it is guest-capable, and is 0 if it is wired-type. For selection 0 or above NCTL, both outputs are 0. Enable bits never affect these outputs.
- R8: The enable register resets to 0. Bits for unimplemented controllers (above NCTL) read 0 whatever is written. A write takes effect at the next rising clock edge.
- R9: The summary register is read-only: a write to its address changes neither it nor the enable register.
- R10: With XLEN=32, the addresses `ADDR_PEND_HI` and `ADDR_ENA_HI` read (and for enables, write) bits 63:32, and the base addresses cover bits 31:0. With XLEN=64, the base addresses cover all 64 bits and the high-half addresses give `csr_hit`=0. Any address that does not decode gives `csr_hit`=0, read data 0, and has no write effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_s_pend | input | NCTL | S-level pending line; bit k-1 belongs to controller k |
| ctl_vs_pend | input | NCTL*NVS | VS-level lines; controller k uses bits [(k-1)*NVS +: NVS] |
| ctl_has_guest | input | NCTL | Type flag per controller: 1 guest-capable, 0 wired-type |
| act_sel | input | SEL_W | Number of the active controller (0 = none) |
| s_deleg | input | 1 | Machine delegation bit 16 for the local interrupt |
| csr_addr | input | 12 | CSR address |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for `csr_addr` (combinational) |
| csr_hit | output | 1 | `csr_addr` decodes to a register of this block |
| m_lpend | output | 1 | Local pending bit 16, machine view |
| s_lpend | output | 1 | Local pending bit 16, supervisor view |
| act_s_pend | output | 1 | S-level pending line of the active controller |
| act_vs_pend | output | NVS | VS-level pending vector of the active controller |

## Verification
The summary fold is tried with the same VS-level pattern on a controller marked guest-capable and then marked wired-type. This separates the OR-with-guest-lines path from the S-only path. The local pending bit is tried with pending and enable landing in the same bit, in different bits, and in the high half only. This shows that the output follows the AND of the two registers and not either one alone. The selection is swept over none, valid low and high numbers, and an out-of-range number, with all enables set and with none set. This separates the forwarding path from the summary path and from the enables. Directed cases cover write timing, writes to the read-only summary, bit 0, unimplemented enable bits and address decode.

// File: rtl/sdei_pkg.sv
package sdei_pkg;

   localparam int unsigned REG_W = 64;

   typedef logic [REG_W-1:0] dvec_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PEND,
      SEL_PEND_HI,
      SEL_ENA,
      SEL_ENA_HI
   } csr_sel_e;

   localparam logic [11:0] DEF_ADDR_PEND    = 12'h7D0;
   localparam logic [11:0] DEF_ADDR_PEND_HI = 12'h7D1;
   localparam logic [11:0] DEF_ADDR_ENA     = 12'h7D4;
   localparam logic [11:0] DEF_ADDR_ENA_HI  = 12'h7D5;

   // Bits 1..n set: the controllers that exist.
   function automatic dvec_t impl_mask(input int unsigned n);
      dvec_t m;
      m = '0;
      for (int unsigned i = 1; i < REG_W; i++) begin
         if (i <= n) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sdei_fold.sv
module sdei_fold
   import sdei_pkg::*;
#(
   parameter int unsigned NCTL = 40,
   parameter int unsigned NVS  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCTL-1:0]     ctl_s_pend,
   input  logic [NCTL*NVS-1:0] ctl_vs_pend,
   input  logic [NCTL-1:0]     ctl_has_guest,
   output dvec_t               pend
);

   assign pend[0] = 1'b0;

   for (genvar k = 0; k < NCTL; k++) begin : g_ctl
      logic vs_any;
      assign vs_any      = |ctl_vs_pend[k*NVS +: NVS];
      assign pend[k+1]   = ctl_s_pend[k] | (ctl_has_guest[k] & vs_any);

      // R2: a wired-type controller with its S line low shows no pending
      a_r2_wired_s_only: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctl_has_guest[k] && !ctl_s_pend[k]) |-> !pend[k+1]);
      // R3: any guest line of a guest-capable controller shows as pending
      a_r3_guest_or: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_has_guest[k] && (ctl_vs_pend[k*NVS +: NVS] != '0)) |-> pend[k+1]);
   end

   if (NCTL < REG_W - 1) begin : g_tail
      assign pend[REG_W-1:NCTL+1] = '0;
   end

endmodule

// File: rtl/sdei_active_fwd.sv
module sdei_active_fwd #(
   parameter int unsigned NCTL  = 40,
   parameter int unsigned NVS   = 3,
   parameter int unsigned SEL_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    act_sel,
   input  logic [NCTL-1:0]     ctl_s_pend,
   input  logic [NCTL*NVS-1:0] ctl_vs_pend,
   input  logic [NCTL-1:0]     ctl_has_guest,
   output logic                act_s_pend,
   output logic [NVS-1:0]      act_vs_pend
);

   localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NCTL);

   always_comb begin
      act_s_pend  = 1'b0;
      act_vs_pend = '0;
      for (int k = 0; k < NCTL; k++) begin
         if (SEL_W'(k + 1) == act_sel) begin
            act_s_pend  = ctl_s_pend[k];
            act_vs_pend = ctl_has_guest[k] ? ctl_vs_pend[k*NVS +: NVS] : '0;
         end
      end
   end

   // R7: no controller selected means nothing forwarded
   a_r7_idle_sel: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_sel == '0) || (act_sel > SEL_MAX)) |-> (!act_s_pend && (act_vs_pend == '0)));

endmodule

// File: rtl/sdei_csr_file.sv
module sdei_csr_file
   import sdei_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NCTL         = 40,
   parameter logic [11:0] ADDR_PEND    = DEF_ADDR_PEND,
   parameter logic [11:0] ADDR_PEND_HI = DEF_ADDR_PEND_HI,
   parameter logic [11:0] ADDR_ENA     = DEF_ADDR_ENA,
   parameter logic [11:0] ADDR_ENA_HI  = DEF_ADDR_ENA_HI
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [11:0]     csr_addr,
   input  logic            csr_wr,
   input  logic [XLEN-1:0] csr_wdata,
   input  dvec_t           pend,
   output dvec_t           ena_q,
   output logic [XLEN-1:0] csr_rdata,
   output logic            csr_hit
);

   localparam dvec_t IMPL = impl_mask(NCTL);

   csr_sel_e sel;
   logic     hit_pend_hi, hit_ena_hi;
   dvec_t    ena_d, rd_src;

   // High-half aliases exist only for the narrow register width.
   if (XLEN == 32) begin : g_hi_decode
      assign hit_pend_hi = (csr_addr == ADDR_PEND_HI);
      assign hit_ena_hi  = (csr_addr == ADDR_ENA_HI);
   end else begin : g_no_hi
      assign hit_pend_hi = 1'b0;
      assign hit_ena_hi  = 1'b0;
   end

   always_comb begin
      if (csr_addr == ADDR_PEND)      sel = SEL_PEND;
      else if (csr_addr == ADDR_ENA)  sel = SEL_ENA;
      else if (hit_pend_hi)           sel = SEL_PEND_HI;
      else if (hit_ena_hi)            sel = SEL_ENA_HI;
      else                            sel = SEL_NONE;
   end

   assign csr_hit = (sel != SEL_NONE);

   always_comb begin
      ena_d = ena_q;
      if (csr_wr) begin
         case (sel)
            SEL_ENA:    ena_d[XLEN-1:0]    = csr_wdata;
            SEL_ENA_HI: ena_d[REG_W-1:32]  = csr_wdata[31:0];
            default:    ena_d              = ena_q;
         endcase
      end
      ena_d = ena_d & IMPL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ena_q <= '0;
      else        ena_q <= ena_d;
   end

   always_comb begin
      case (sel)
         SEL_PEND:    rd_src = pend;
         SEL_PEND_HI: rd_src = {32'b0, pend[REG_W-1:32]};
         SEL_ENA:     rd_src = ena_q;
         SEL_ENA_HI:  rd_src = {32'b0, ena_q[REG_W-1:32]};
         default:     rd_src = '0;
      endcase
   end

   assign csr_rdata = rd_src[XLEN-1:0];

   // R1: bit 0 of either register never reads as set
   a_r1_bit0_read: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_addr == ADDR_PEND) || (csr_addr == ADDR_ENA)) |-> !csr_rdata[0]);
   // R8: an enable write lands on the next edge, masked to real controllers
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csr_wr && (csr_addr == ADDR_ENA)) |->
         (ena_q[XLEN-1:0] == ($past(csr_wdata) & IMPL[XLEN-1:0])));
   // R9: writing the summary address leaves the enables alone
   a_r9_pend_ro: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csr_wr && (csr_addr == ADDR_PEND)) |-> (ena_q == $past(ena_q)));
   // R10: a missed decode returns zero data
   a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_hit |-> (csr_rdata == '0));

endmodule

// File: rtl/dom_eint_summary.sv
module dom_eint_summary
   import sdei_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NCTL         = 40,
   parameter int unsigned NVS          = 3,
   parameter int unsigned SEL_W        = 6,
   parameter logic [11:0] ADDR_PEND    = DEF_ADDR_PEND,
   parameter logic [11:0] ADDR_PEND_HI = DEF_ADDR_PEND_HI,
   parameter logic [11:0] ADDR_ENA     = DEF_ADDR_ENA,
   parameter logic [11:0] ADDR_ENA_HI  = DEF_ADDR_ENA_HI
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCTL-1:0]     ctl_s_pend,
   input  logic [NCTL*NVS-1:0] ctl_vs_pend,
   input  logic [NCTL-1:0]     ctl_has_guest,
   input  logic [SEL_W-1:0]    act_sel,
   input  logic                s_deleg,
   input  logic [11:0]         csr_addr,
   input  logic                csr_wr,
   input  logic [XLEN-1:0]     csr_wdata,
   output logic [XLEN-1:0]     csr_rdata,
   output logic                csr_hit,
   output logic                m_lpend,
   output logic                s_lpend,
   output logic                act_s_pend,
   output logic [NVS-1:0]      act_vs_pend
);

   initial begin : p_param_chk
      assert (XLEN == 32 || XLEN == 64) else $fatal(1, "XLEN must be 32 or 64");
      assert (NCTL >= 1 && NCTL <= REG_W - 1) else $fatal(1, "NCTL out of range");
      assert (NVS >= 1) else $fatal(1, "NVS must be at least 1");
      assert ((2 ** SEL_W) > NCTL) else $fatal(1, "SEL_W too narrow for NCTL");
   end

   dvec_t pend, ena_q;

   sdei_fold #(.NCTL(NCTL), .NVS(NVS)) u_fold (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_s_pend    (ctl_s_pend),
      .ctl_vs_pend   (ctl_vs_pend),
      .ctl_has_guest (ctl_has_guest),
      .pend          (pend)
   );

   sdei_csr_file #(
      .XLEN(XLEN), .NCTL(NCTL),
      .ADDR_PEND(ADDR_PEND), .ADDR_PEND_HI(ADDR_PEND_HI),
      .ADDR_ENA(ADDR_ENA), .ADDR_ENA_HI(ADDR_ENA_HI)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_addr  (csr_addr),
      .csr_wr    (csr_wr),
      .csr_wdata (csr_wdata),
      .pend      (pend),
      .ena_q     (ena_q),
      .csr_rdata (csr_rdata),
      .csr_hit   (csr_hit)
   );

   sdei_active_fwd #(.NCTL(NCTL), .NVS(NVS), .SEL_W(SEL_W)) u_fwd (
      .clk           (clk),
      .rst_n         (rst_n),
      .act_sel       (act_sel),
      .ctl_s_pend    (ctl_s_pend),
      .ctl_vs_pend   (ctl_vs_pend),
      .ctl_has_guest (ctl_has_guest),
      .act_s_pend    (act_s_pend),
      .act_vs_pend   (act_vs_pend)
   );

   assign m_lpend = |(pend & ena_q);
   assign s_lpend = m_lpend & s_deleg;

   // R5: local pending needs at least one enabled bit
   a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q == '0) |-> !m_lpend);
   // R6: supervisor copy is masked by delegation
   a_r6_no_deleg: assert property (@(posedge clk) disable iff (!rst_n)
      !s_deleg |-> !s_lpend);
   a_r6_deleg_copy: assert property (@(posedge clk) disable iff (!rst_n)
      s_deleg |-> (s_lpend == m_lpend));

endmodule

// File: tb/dom_eint_summary_test.sv
module dom_eint_summary_test;

   localparam int NCTL = 40;
   localparam int NVS  = 3;
   localparam int SELW = 6;
   localparam logic [11:0] A_P  = 12'h7D0;
   localparam logic [11:0] A_PH = 12'h7D1;
   localparam logic [11:0] A_E  = 12'h7D4;
   localparam logic [11:0] A_EH = 12'h7D5;

   typedef struct packed {
      logic [NCTL-1:0]     sp;
      logic [NCTL*NVS-1:0] vs;
      logic [NCTL-1:0]     gst;
      logic [31:0]         elo;
      logic [31:0]         ehi;
      logic                dg;
      logic [SELW-1:0]     sel;
      logic                exp_m;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{sp:'0,             vs:'0,          gst:'0,      elo:32'hFFFF_FFFF, ehi:32'hFFFF_FFFF, dg:1'b1, sel:6'd1,  exp_m:1'b0},
      '{sp:40'h1,          vs:'0,          gst:'0,      elo:32'h2,         ehi:32'h0,         dg:1'b0, sel:6'd1,  exp_m:1'b1},
      '{sp:'0,             vs:120'h20,     gst:40'h2,   elo:32'h4,         ehi:32'h0,         dg:1'b1, sel:6'd2,  exp_m:1'b1},
      '{sp:'0,             vs:120'h20,     gst:'0,      elo:32'h4,         ehi:32'h0,         dg:1'b1, sel:6'd2,  exp_m:1'b0},
      '{sp:40'h80_0000_0000, vs:'0,        gst:'0,      elo:32'h0,         ehi:32'h100,       dg:1'b1, sel:6'd0,  exp_m:1'b1},
      '{sp:40'h80_0000_0000, vs:'0,        gst:'0,      elo:32'hFFFF_FFFE, ehi:32'h0,         dg:1'b1, sel:6'd0,  exp_m:1'b0},
      '{sp:40'hFF_FFFF_FFFF, vs:'0,        gst:'0,      elo:32'h1,         ehi:32'h0,         dg:1'b1, sel:6'd50, exp_m:1'b0},
      '{sp:40'h4,          vs:120'h1C0,    gst:40'h4,   elo:32'h8,         ehi:32'h0,         dg:1'b1, sel:6'd3,  exp_m:1'b1}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NCTL-1:0]     ctl_s_pend = '0;
   logic [NCTL*NVS-1:0] ctl_vs_pend = '0;
   logic [NCTL-1:0]     ctl_has_guest = '0;
   logic [SELW-1:0]     act_sel = '0;
   logic                s_deleg = 1'b0;
   logic [11:0]         csr_addr = 12'h000;
   logic                csr_wr = 1'b0;
   logic [31:0]         csr_wdata = '0;
   logic [31:0]         csr_rdata;
   logic                csr_hit;
   logic                m_lpend, s_lpend, act_s_pend;
   logic [NVS-1:0]      act_vs_pend;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   dom_eint_summary #(.XLEN(32), .NCTL(NCTL), .NVS(NVS), .SEL_W(SELW)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_s_pend(ctl_s_pend), .ctl_vs_pend(ctl_vs_pend),
      .ctl_has_guest(ctl_has_guest), .act_sel(act_sel), .s_deleg(s_deleg),
      .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .csr_hit(csr_hit), .m_lpend(m_lpend), .s_lpend(s_lpend),
      .act_s_pend(act_s_pend), .act_vs_pend(act_vs_pend)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
      csr_addr = a;
      #1;
      d = csr_rdata;
   endtask

   // Summary as the requirements define it (R2, R3).
   function automatic logic [63:0] model_pend(input vec_t v);
      logic [63:0] p;
      p = '0;
      for (int k = 0; k < NCTL; k++)
         p[k+1] = v.sp[k] | (v.gst[k] & (|v.vs[k*NVS +: NVS]));
      return p;
   endfunction

   function automatic logic [63:0] model_mask();
      logic [63:0] m;
      m = '0;
      for (int i = 1; i <= NCTL; i++) m[i] = 1'b1;
      return m;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      logic [63:0] ep, ee;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      csr_read(A_E, rd);  check("R8 enable reset lo", rd, 0);
      csr_read(A_EH, rd); check("R8 enable reset hi", rd, 0);
      check("R5 m_lpend at reset", m_lpend, 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ctl_s_pend = VEC[i].sp; ctl_vs_pend = VEC[i].vs; ctl_has_guest = VEC[i].gst;
         s_deleg = VEC[i].dg; act_sel = VEC[i].sel;
         csr_write(A_E, VEC[i].elo);
         csr_write(A_EH, VEC[i].ehi);
         #2;
         ep = model_pend(VEC[i]);
         ee = {VEC[i].ehi, VEC[i].elo} & model_mask();
         check("R5 m_lpend", m_lpend, VEC[i].exp_m);
         check("R6 s_lpend", s_lpend, VEC[i].exp_m & VEC[i].dg);
         csr_read(A_P, rd);  check("R2 R3 R4 summary lo", rd, ep[31:0]);
         csr_read(A_PH, rd); check("R10 R4 summary hi", rd, ep[63:32]);
         csr_read(A_E, rd);  check("R1 R8 enable lo", rd, ee[31:0]);
         csr_read(A_EH, rd); check("R8 R10 enable hi", rd, ee[63:32]);
         if (VEC[i].sel >= 1 && VEC[i].sel <= NCTL) begin
            check("R7 act_s", act_s_pend, VEC[i].sp[VEC[i].sel-1]);
            check("R7 act_vs", act_vs_pend,
                  VEC[i].gst[VEC[i].sel-1] ? VEC[i].vs[(VEC[i].sel-1)*NVS +: NVS] : '0);
         end else begin
            check("R7 act_s idle", act_s_pend, 0);
            check("R7 act_vs idle", act_vs_pend, 0);
         end
      end

      // R8: write timing, enable takes effect only after the edge
      @(negedge clk);
      ctl_s_pend = 40'h1; ctl_has_guest = '0; ctl_vs_pend = '0; s_deleg = 1'b1;
      csr_write(A_E, 32'h0);
      csr_write(A_EH, 32'h0);
      @(negedge clk);
      csr_addr = A_E; csr_wdata = 32'h2; csr_wr = 1'b1;
      #2; check("R8 before edge", m_lpend, 0);
      @(negedge clk); csr_wr = 1'b0;
      #2; check("R8 after edge", m_lpend, 1);

      // R9: writes to the summary address do nothing
      csr_write(A_P, 32'hFFFF_FFFF);
      csr_write(A_PH, 32'hFFFF_FFFF);
      #2;
      csr_read(A_P, rd);  check("R9 summary lo unchanged", rd, 32'h2);
      csr_read(A_PH, rd); check("R9 summary hi unchanged", rd, 0);
      csr_read(A_E, rd);  check("R9 enable unchanged", rd, 32'h2);

      // R1: bit 0 of the enable cannot be set
      csr_write(A_E, 32'h1);
      #2; csr_read(A_E, rd); check("R1 enable bit0", rd, 0);
      check("R1 R5 no pending from bit0", m_lpend, 0);

      // R10: decode of alias and unknown addresses
      csr_read(A_PH, rd); check("R10 hi alias hit", csr_hit, 1);
      csr_read(12'h123, rd);
      check("R10 miss hit", csr_hit, 0);
      check("R10 miss data", rd, 0);
      csr_write(12'h123, 32'hFFFF_FFFF);
      #2; csr_read(A_E, rd); check("R10 miss no write", rd, 0);

      // R7: enables never touch the forwarded lines
      act_sel = 6'd1;
      csr_write(A_E, 32'h0);
      #2; check("R7 fwd without enable", act_s_pend, 1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule